// File: doc/BRIEF.md
# Parallel Full-Window Generator

This block turns a raster stream of image pixels into convolution windows. Each input beat carries one complete pixel, with every channel side by side. Each output beat carries a whole kernel window of K = K_W × K_H pixels at once. A fully unrolled dot-product stage can therefore consume one window per beat without replaying any data.

The current pixel and its recent neighbours are held in short per-row shift registers. Earlier image rows come back through circular row-delay buffers, one per extra kernel row, so that all kernel rows arrive at the same column together. A position tracker follows the column, the row and the stride phase in each direction. When an accepted pixel completes a window at a stride-aligned position, that window is captured into an output register. Every other pixel only updates the storage.

Both sides are valid/ready streams. When the output register is full and not being drained, the input is stalled and all storage is frozen. Image size, kernel size, strides, channel count and element width are parameters.

Top module: `swg_full_window`

## Requirements
- R1: While rst_n is low, out_valid and in_ready are low. No later than three clock cycles after rst_n rises, in_ready is high and out_valid is low.
- R2: Out of reset, in_ready is low exactly when out_valid is high and out_ready is low.
- R3: While out_valid is high and out_ready is low, out_valid stays high and out_data stays unchanged in the next cycle.
- R4: Consider a window whose top-left pixel sits at image row r0, column c0. Kernel element e = kr·K_W + kc occupies out_data bits [e·C·EW +: C·EW] and holds pixel (r0+kr, c0+kc). Inside a pixel, channel ch occupies bits [ch·EW +: EW], exactly as on in_data.
- R5: Windows are emitted for c0 = 0, STRIDE_W, 2·STRIDE_W, … with c0+K_W ≤ IMG_W, and for r0 = 0, STRIDE_H, … with r0+K_H ≤ IMG_H. They come in row-major order, each exactly once per frame, and there are no other beats.
- R6: A window beat becomes valid in the cycle after the pixel that completes it (bottom-right element) is accepted. An output beat that is drained while no pixel is accepted leaves out_valid low.
- R7: With K_H = 1 the block builds no row-delay buffer and still meets R4 and R5.
- R8: Frames follow each other with no gap. Pixel IMG_W·IMG_H of the stream is row 0, column 0 of the next frame, and that frame yields the same window positions.
- R9: Idle cycles on in_valid and random stalls on out_ready change neither the content nor the order of the windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released internally on the clock |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block accepts the input pixel |
| in_data | input | CHANNELS·ELEM_W | One pixel, channel 0 in the low bits |
| out_valid | output | 1 | Window beat present |
| out_ready | input | 1 | Downstream accepts the window |
| out_data | output | K_W·K_H·CHANNELS·ELEM_W | Full window, kernel element 0 in the low bits |

## Verification
The reference model rebuilds every window from a stored copy of each frame and compares each beat in order. Three geometries are covered: a 3×3 window at unit stride, a 3×2 window with unequal strides of 2 and 3, and a one-row kernel of width 4. In each of them, columns and rows that the stride skips must produce no beat. A design with a misaligned stride phase or an off-by-one row delay would shift a whole row of the window or emit extra beats, and the first compare would catch it. Two frames are run back to back to expose counters that fail to wrap at the end of a frame. Random input gaps and output stalls are applied throughout. Storage that advanced during a stall would drop or duplicate pixels, and an output register that was not held would change its data under back-pressure.

// File: rtl/swg_pkg.sv
package swg_pkg;
  // Stride phase of column (or row) 0, chosen so that the first full window lands on phase 0.
  function automatic int phase0(input int kern, input int stride);
    return (stride - ((kern - 1) % stride)) % stride;
  endfunction
endpackage

// File: rtl/swg_line_buffer.sv
module swg_line_buffer #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] ptr, ptr_n;

  // Oldest entry is read at the same slot the new pixel overwrites: one row of delay.
  assign dout = mem[ptr];

  always_comb begin
    ptr_n = (ptr == PTR_LAST) ? '0 : ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr <= '0;
    else if (adv) ptr <= ptr_n;
  end

  always_ff @(posedge clk) begin
    if (adv) mem[ptr] <= din;
  end
endmodule

// File: rtl/swg_row_taps.sv
module swg_row_taps #(
  parameter int DEPTH = 2,
  parameter int WIDTH = 8
) (
  input  logic                   clk,
  input  logic                   adv,
  input  logic [WIDTH-1:0]       din,
  output logic [DEPTH*WIDTH-1:0] taps
);
  logic [DEPTH-1:0][WIDTH-1:0] sr, sr_n;

  // Tap 0 is the previous pixel; higher taps are older.
  always_comb begin
    sr_n[0] = din;
    for (int j = 1; j < DEPTH; j++) sr_n[j] = sr[j-1];
  end

  always_ff @(posedge clk) begin
    if (adv) sr <= sr_n;
  end

  assign taps = sr;
endmodule

// File: rtl/swg_pos_tracker.sv
module swg_pos_tracker #(
  parameter int IMG_W    = 8,
  parameter int IMG_H    = 6,
  parameter int K_W      = 3,
  parameter int K_H      = 3,
  parameter int STRIDE_W = 1,
  parameter int STRIDE_H = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output logic hit
);
  localparam int CW  = (IMG_W > 1) ? $clog2(IMG_W) : 1;
  localparam int RW  = (IMG_H > 1) ? $clog2(IMG_H) : 1;
  localparam int CPW = (STRIDE_W > 1) ? $clog2(STRIDE_W) : 1;
  localparam int RPW = (STRIDE_H > 1) ? $clog2(STRIDE_H) : 1;
  localparam logic [CW-1:0]  COL_LAST = CW'(IMG_W - 1);
  localparam logic [RW-1:0]  ROW_LAST = RW'(IMG_H - 1);
  localparam logic [CPW-1:0] CPH_LAST = CPW'(STRIDE_W - 1);
  localparam logic [RPW-1:0] RPH_LAST = RPW'(STRIDE_H - 1);
  localparam logic [CPW-1:0] CPH_INIT = CPW'(swg_pkg::phase0(K_W, STRIDE_W));
  localparam logic [RPW-1:0] RPH_INIT = RPW'(swg_pkg::phase0(K_H, STRIDE_H));

  logic [CW-1:0]  col, col_n;
  logic [RW-1:0]  row, row_n;
  logic [CPW-1:0] cph, cph_n;
  logic [RPW-1:0] rph, rph_n;
  logic col_ok, row_ok;

  always_comb begin
    col_n = col;
    row_n = row;
    cph_n = cph;
    rph_n = rph;
    if (col == COL_LAST) begin
      col_n = '0;
      cph_n = CPH_INIT;
      if (row == ROW_LAST) begin
        row_n = '0;
        rph_n = RPH_INIT;
      end else begin
        row_n = row + 1'b1;
        rph_n = (rph == RPH_LAST) ? '0 : rph + 1'b1;
      end
    end else begin
      col_n = col + 1'b1;
      cph_n = (cph == CPH_LAST) ? '0 : cph + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col <= '0;
      row <= '0;
      cph <= CPH_INIT;
      rph <= RPH_INIT;
    end else if (adv) begin
      col <= col_n;
      row <= row_n;
      cph <= cph_n;
      rph <= rph_n;
    end
  end

  generate
    if (K_W > 1) begin : g_col_min
      localparam logic [CW-1:0] COL_MIN = CW'(K_W - 1);
      assign col_ok = (col >= COL_MIN);
    end else begin : g_col_any
      assign col_ok = 1'b1;
    end
    if (K_H > 1) begin : g_row_min
      localparam logic [RW-1:0] ROW_MIN = RW'(K_H - 1);
      assign row_ok = (row >= ROW_MIN);
    end else begin : g_row_any
      assign row_ok = 1'b1;
    end
  endgenerate

  assign hit = col_ok && row_ok && (cph == '0) && (rph == '0);
endmodule

// File: rtl/swg_full_window.sv
module swg_full_window #(
  parameter int IMG_W    = 8,
  parameter int IMG_H    = 6,
  parameter int K_W      = 3,
  parameter int K_H      = 3,
  parameter int STRIDE_W = 1,
  parameter int STRIDE_H = 1,
  parameter int CHANNELS = 4,
  parameter int ELEM_W   = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 in_valid,
  output logic                                 in_ready,
  input  logic [CHANNELS*ELEM_W-1:0]           in_data,
  output logic                                 out_valid,
  input  logic                                 out_ready,
  output logic [K_W*K_H*CHANNELS*ELEM_W-1:0]   out_data
);
  localparam int PIX_W = CHANNELS * ELEM_W;
  localparam int TAPS  = K_W * K_H;
  localparam int WIN_W = TAPS * PIX_W;

  logic [1:0] rst_pipe;
  logic       rst_q;
  logic       adv, hit;
  logic       ov, ov_n;
  logic [WIN_W-1:0] odata, win_next;
  logic [K_H-1:0][PIX_W-1:0] stream;

  // Reset asserts at once and is released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  assign in_ready = rst_q & (~ov | out_ready);
  assign adv      = in_valid & in_ready;

  swg_pos_tracker #(
    .IMG_W(IMG_W), .IMG_H(IMG_H), .K_W(K_W), .K_H(K_H),
    .STRIDE_W(STRIDE_W), .STRIDE_H(STRIDE_H)
  ) u_pos (
    .clk(clk), .rst_n(rst_q), .adv(adv), .hit(hit)
  );

  // Bottom kernel row is the live pixel; each row above is one image row older.
  assign stream[K_H-1] = in_data;
  generate
    for (genvar i = 0; i < K_H - 1; i++) begin : g_lines
      swg_line_buffer #(.DEPTH(IMG_W), .WIDTH(PIX_W)) u_line (
        .clk(clk), .rst_n(rst_q), .adv(adv),
        .din(stream[i+1]), .dout(stream[i])
      );
    end

    for (genvar r = 0; r < K_H; r++) begin : g_rows
      if (K_W > 1) begin : g_taps
        logic [(K_W-1)*PIX_W-1:0] taps;
        swg_row_taps #(.DEPTH(K_W - 1), .WIDTH(PIX_W)) u_taps (
          .clk(clk), .adv(adv), .din(stream[r]), .taps(taps)
        );
        for (genvar kc = 0; kc < K_W - 1; kc++) begin : g_old
          assign win_next[(r*K_W+kc)*PIX_W +: PIX_W] = taps[(K_W-2-kc)*PIX_W +: PIX_W];
        end
      end
      assign win_next[(r*K_W+K_W-1)*PIX_W +: PIX_W] = stream[r];
    end
  endgenerate

  always_comb begin
    ov_n = ov;
    if (adv && hit)     ov_n = 1'b1;
    else if (out_ready) ov_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ov <= 1'b0;
    else        ov <= ov_n;
  end

  always_ff @(posedge clk) begin
    if (adv && hit) odata <= win_next;
  end

  assign out_valid = ov;
  assign out_data  = odata;
endmodule

// File: rtl/swg_full_window_sva.sv
module swg_full_window_sva #(
  parameter int WIN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIN_W-1:0] out_data
);
  assert_backpressure_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_stall_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_beat_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(!out_valid || out_ready)) |-> $past(in_valid && in_ready));

  assert_drain_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && !(in_valid && in_ready)) |=> !out_valid);
endmodule

bind swg_full_window swg_full_window_sva #(.WIN_W(WIN_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/swg_full_window_test.sv
module swg_full_window_lane #(
  parameter int LANE = 0,
  parameter int W = 6, parameter int H = 5,
  parameter int KW = 3, parameter int KH = 3,
  parameter int SW = 1, parameter int SH = 1,
  parameter int C = 2, parameter int EW = 8,
  parameter int NF = 2
) (
  input  logic clk,
  input  logic rst_n,
  output int   n_chk,
  output int   n_bad,
  output logic done
);
  localparam int PIX_W = C * EW;
  localparam int WIN_W = KW * KH * PIX_W;
  localparam int FPX   = W * H;
  localparam int TOTAL = NF * FPX;
  localparam int WPF   = ((W - KW) / SW + 1) * ((H - KH) / SH + 1);

  logic in_valid, in_ready, out_valid, out_ready;
  logic [PIX_W-1:0] in_data;
  logic [WIN_W-1:0] out_data;
  logic [WIN_W-1:0] expq [$];

  swg_full_window #(
    .IMG_W(W), .IMG_H(H), .K_W(KW), .K_H(KH),
    .STRIDE_W(SW), .STRIDE_H(SH), .CHANNELS(C), .ELEM_W(EW)
  ) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  function automatic logic [PIX_W-1:0] pix(input int idx);
    logic [PIX_W-1:0] p;
    int f = idx / FPX;
    int r = (idx % FPX) / W;
    int c = idx % W;
    for (int ch = 0; ch < C; ch++)
      p[ch*EW +: EW] = EW'(f*37 + r*11 + c*5 + ch*3 + LANE*13 + 1);
    return p;
  endfunction

  function automatic bit completes(input int idx);
    int r = (idx % FPX) / W;
    int c = idx % W;
    return (c >= KW-1) && (r >= KH-1) && ((c-KW+1) % SW == 0) && ((r-KH+1) % SH == 0);
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [WIN_W-1:0] act, input logic [WIN_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s lane %0d: actual %h expected %h", tag, LANE, act, exp);
    end
  endtask

  initial begin
    logic [WIN_W-1:0] w;
    int  sent = 0;
    int  got  = 0;
    bit  pend = 0;
    n_chk = 0; n_bad = 0; done = 0;
    in_valid = 0; in_data = '0; out_ready = 0;
    // Reference windows, row-major per frame (R4, R5, R8).
    for (int f = 0; f < NF; f++)
      for (int r0 = 0; r0 + KH <= H; r0 += SH)
        for (int c0 = 0; c0 + KW <= W; c0 += SW) begin
          for (int kr = 0; kr < KH; kr++)
            for (int kc = 0; kc < KW; kc++)
              w[(kr*KW+kc)*PIX_W +: PIX_W] = pix(f*FPX + (r0+kr)*W + c0 + kc);
          expq.push_back(w);
        end

    @(negedge clk);
    chk(!out_valid && !in_ready, "R1 in reset", WIN_W'({out_valid, in_ready}), '0);
    wait (rst_n === 1'b1);
    repeat (3) @(negedge clk);
    chk(!out_valid && in_ready, "R1 after release", WIN_W'({out_valid, in_ready}), WIN_W'(1));

    while (1) begin
      @(negedge clk);
      if (pend) begin
        if (completes(sent))
          chk(out_valid, "R6 beat after completing pixel", WIN_W'(out_valid), WIN_W'(1));
        sent++;
      end
      if (sent == TOTAL && expq.size() == 0 && !out_valid) break;
      out_ready = ($urandom_range(0, 99) < 65);
      // R9: random idle cycles on the input; a raised valid holds until accepted.
      if (sent < TOTAL) begin
        if (!in_valid || pend) in_valid = ($urandom_range(0, 99) < 75);
        in_data = pix(sent);
      end else begin
        in_valid = 0;
      end
      if (out_valid && out_ready) begin
        if (expq.size() == 0) begin
          chk(0, "R5 unexpected beat", out_data, '0);
        end else begin
          w = expq.pop_front();
          chk(out_data === w,
              (KH == 1) ? "R7 window" : ((got >= WPF) ? "R8 window" : "R4 window"),
              out_data, w);
          got++;
        end
      end
      #1;
      pend = in_valid && in_ready;
      if (out_valid && !out_ready)
        chk(!in_ready, "R2 stall blocks input", WIN_W'(in_ready), '0);
    end
    chk(got == NF * WPF, "R9 beat count", WIN_W'(got), WIN_W'(NF * WPF));
    done = 1;
  end
endmodule

module swg_full_window_test;
  logic clk = 0;
  logic rst_n;
  int   ca, cb, cc, ba, bb, bc;
  logic da, db, dc;

  always #5 clk = ~clk;

  // 3x3 window, unit stride.
  swg_full_window_lane #(.LANE(0), .W(6), .H(5), .KW(3), .KH(3), .SW(1), .SH(1), .C(2), .EW(8))
    lane_a (.clk(clk), .rst_n(rst_n), .n_chk(ca), .n_bad(ba), .done(da));
  // 3 wide by 2 high, strides 2 and 3.
  swg_full_window_lane #(.LANE(1), .W(7), .H(6), .KW(3), .KH(2), .SW(2), .SH(3), .C(3), .EW(6))
    lane_b (.clk(clk), .rst_n(rst_n), .n_chk(cb), .n_bad(bb), .done(db));
  // R7: one-row kernel, no row-delay buffers.
  swg_full_window_lane #(.LANE(2), .W(9), .H(1), .KW(4), .KH(1), .SW(2), .SH(1), .C(2), .EW(5))
    lane_c (.clk(clk), .rst_n(rst_n), .n_chk(cc), .n_bad(bc), .done(dc));

  initial begin
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
  end

  initial begin
    int cyc = 0;
    int chks, bads;
    while (!(da === 1'b1 && db === 1'b1 && dc === 1'b1) && cyc < 50000) begin
      @(posedge clk);
      cyc++;
    end
    chks = ca + cb + cc;
    bads = ba + bb + bc;
    if (!(da === 1'b1 && db === 1'b1 && dc === 1'b1)) begin
      chks++;
      bads++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    end
    $display("== %0d vectors applied, %0d miscompares ==", chks, bads);
    $finish;
  end
endmodule